// File: doc/BRIEF.md
# Serial Control Port with Register Bank and Power-State Gate

This block is the slave side of a byte-oriented serial control port. An external controller pulls the active-low select low and clocks in instruction bytes, most significant bit first. Each first byte carries a power-state bit, a 4-bit register address, a read/write flag and a flag that says whether a data byte follows. A write loads the data byte into one of ten 8-bit configuration registers. A read shifts the addressed register out on a serial output, and that output has a separate driver-enable signal. The registers are plain storage, and their contents are exported as one flat vector.

The serial select, clock and data pins are sampled by the system clock, and edges are found inside that clock domain. The control logic is one state machine with three states. ST_CMD collects an instruction byte. ST_WDATA collects the data byte of a write. ST_RDATA shifts out the data byte of a read. When an instruction byte completes in ST_CMD, the machine takes one of three transitions: CMD→CMD for a single-byte instruction, CMD→WDATA for a write, and CMD→RDATA for a read. When a data byte completes, WDATA→CMD or RDATA→CMD follows. If select rises while a byte is partly shifted, the transition ABORT→CMD is taken from any state. If select rises on a byte boundary, the state is kept, so the data byte may arrive in a later select window.

The power bit of every instruction sets the power-down output. A frame-sync gate holds the framed-data output enable low while the part is powered down. After a power-up it keeps the enable low until the second frame-sync rising edge.

Top module: `scp_ctrl_port`

## Requirements
- R1: After reset, pdown_o is 1, every byte of reg_bank_o is 0x00, and sdo_en and pcm_oe are 0.
- R2: sdi is sampled on falling sclk edges while csn is low, MSB first. A write uses byte 1 = {P, A[3:0], 1'b0, 1'b1, x} and is followed by a data byte in the same select window. The data byte lands in the slot for address A. The address-to-slot map is 0→0, 1→1, 2→2, 4→3, 5→4, 6→5, 7→6, 8→7, 9→8, 10→9, and slot n is reg_bank_o[8n+7:8n].
- R3: The data byte of a write may instead arrive in a separate select window, after csn has gone high on a byte boundary.
- R4: A read uses byte 1 with bit 2 = 1 and bit 1 = 1. During the next 8 sclk pulses, sdo_en is 1 while csn is low, and sdo carries the addressed slot MSB first, each bit updated on a rising sclk edge. This holds whether the data byte is in the same select window or a later one.
- R5: sdo_en is 0 whenever csn is high.
- R6: Bit 7 of every instruction byte sets pdown_o: 1 means power down, 0 means power up. A write takes effect in either power state.
- R7: A byte 1 with bit 1 = 0 is a single-byte power command. No data byte follows, and the next byte is decoded as a new instruction.
- R8: If csn rises after 1 to 7 sclk pulses of a byte, the partial byte is discarded and the next byte is decoded as a new instruction.
- R9: For an address outside the map, only the P bit takes effect. A write consumes its data byte and changes no slot, and a read returns 0x00.
- R10: pcm_oe is 0 while pdown_o is 1. After a power-up, pcm_oe goes to 1 on the second rising edge of fs.
- R11: With csn held low throughout, successive instructions are decoded one after another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| csn | input | 1 | Active-low serial select |
| sclk | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in |
| fs | input | 1 | Frame-sync pulse |
| sdo | output | 1 | Serial read data |
| sdo_en | output | 1 | Drive enable for the tri-state read-data pad |
| pdown_o | output | 1 | Power-down state (1 = down) |
| pcm_oe | output | 1 | Drive enable for the framed data output |
| reg_bank_o | output | 80 | Ten configuration bytes, slot n at bits 8n+7:8n |

## Verification
The checks assume that csn, sclk, sdi and fs are synchronous to clk. They also assume that each sclk level lasts at least two clk cycles, that csn changes only while sclk is low, and that sdi is settled before a falling sclk edge. Under those assumptions, a select held high for four samples leaves the register bank and the power state untouched, and the read-data enable stays off. The stimulus changes inputs only on falling clk edges, uses four-cycle sclk half periods, and moves csn with sclk low and two cycles of margin on each side.

// File: rtl/scp_pkg.sv
package scp_pkg;

    localparam int DW     = 8;
    localparam int NSLOT  = 10;
    localparam int SLOT_W = $clog2(NSLOT);

    typedef enum logic [1:0] {
        ST_CMD   = 2'd0,
        ST_WDATA = 2'd1,
        ST_RDATA = 2'd2
    } scp_state_e;

    typedef struct packed {
        logic              valid;
        logic [SLOT_W-1:0] idx;
    } slot_t;

    // maps the 4-bit instruction address onto a dense storage slot
    function automatic slot_t addr_to_slot(input logic [3:0] a);
        slot_t s;
        s.valid = 1'b1;
        unique case (a)
            4'd0:    s.idx = SLOT_W'(0);
            4'd1:    s.idx = SLOT_W'(1);
            4'd2:    s.idx = SLOT_W'(2);
            4'd4:    s.idx = SLOT_W'(3);
            4'd5:    s.idx = SLOT_W'(4);
            4'd6:    s.idx = SLOT_W'(5);
            4'd7:    s.idx = SLOT_W'(6);
            4'd8:    s.idx = SLOT_W'(7);
            4'd9:    s.idx = SLOT_W'(8);
            4'd10:   s.idx = SLOT_W'(9);
            default: begin
                s.valid = 1'b0;
                s.idx   = '0;
            end
        endcase
        return s;
    endfunction

endpackage

// File: rtl/scp_edge_sync.sv
module scp_edge_sync #(
    parameter int         W       = 4,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] q,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= RST_VAL;
            prev <= RST_VAL;
        end else begin
            q    <= din;
            prev <= q;
        end
    end

    assign rise = q & ~prev;
    assign fall = ~q & prev;
endmodule

// File: rtl/scp_regbank.sv
module scp_regbank #(
    parameter int DW     = 8,
    parameter int NSLOT  = 10,
    localparam int IW    = $clog2(NSLOT)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we_i,
    input  logic [IW-1:0]       widx_i,
    input  logic [DW-1:0]       wdata_i,
    input  logic [IW-1:0]       ridx_i,
    output logic [DW-1:0]       rdata_o,
    output logic [NSLOT*DW-1:0] bank_o
);
    logic [DW-1:0] mem [NSLOT];

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                            mem[g] <= '0;
            else if (we_i && widx_i == IW'(g))     mem[g] <= wdata_i;
        end
        assign bank_o[g*DW +: DW] = mem[g];
    end

    always_comb begin
        rdata_o = '0;
        for (int i = 0; i < NSLOT; i++)
            if (ridx_i == IW'(i)) rdata_o = mem[i];
    end
endmodule

// File: rtl/scp_fs_gate.sv
module scp_fs_gate #(
    parameter int FS_WAIT = 2,
    localparam int CW     = $clog2(FS_WAIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pdown_i,
    input  logic fs_rise_i,
    output logic pcm_oe_o
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                      cnt <= '0;
        else if (pdown_i)                                cnt <= '0;
        else if (fs_rise_i && cnt != CW'(FS_WAIT))       cnt <= cnt + 1'b1;
    end

    assign pcm_oe_o = !pdown_i && (cnt == CW'(FS_WAIT));
endmodule

// File: rtl/scp_ctrl_port.sv
module scp_ctrl_port
    import scp_pkg::*;
#(
    parameter int FS_WAIT = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                csn,
    input  logic                sclk,
    input  logic                sdi,
    input  logic                fs,
    output logic                sdo,
    output logic                sdo_en,
    output logic                pdown_o,
    output logic                pcm_oe,
    output logic [NSLOT*DW-1:0] reg_bank_o
);
    localparam int BCW = $clog2(DW);

    // pin sampling: {fs, sdi, sclk, csn}
    logic [3:0] pin_q, pin_r, pin_f;
    scp_edge_sync #(.W(4), .RST_VAL(4'b0001)) u_sync (
        .clk(clk), .rst_n(rst_n), .din({fs, sdi, sclk, csn}),
        .q(pin_q), .rise(pin_r), .fall(pin_f)
    );

    logic csn_q, sdi_q, sclk_rise, sclk_fall, fs_rise;
    assign csn_q     = pin_q[0];
    assign sclk_rise = pin_r[1];
    assign sclk_fall = pin_f[1];
    assign sdi_q     = pin_q[2];
    assign fs_rise   = pin_r[3];

    scp_state_e    state, state_nx;
    logic [BCW-1:0] bitcnt;
    logic [DW-1:0]  shin, shout;
    logic [DW-1:0]  byte_in, rdata;
    slot_t          cur_slot, wr_slot;
    logic           shift_en, byte_done, abort, we;

    assign shift_en  = sclk_fall && !csn_q;
    assign byte_done = shift_en && bitcnt == BCW'(DW - 1);
    assign abort     = csn_q && bitcnt != '0;
    assign byte_in   = {shin[DW-2:0], sdi_q};
    assign cur_slot  = addr_to_slot(byte_in[6:3]);
    assign we        = byte_done && state == ST_WDATA && wr_slot.valid;

    scp_regbank #(.DW(DW), .NSLOT(NSLOT)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .we_i(we), .widx_i(wr_slot.idx), .wdata_i(byte_in),
        .ridx_i(cur_slot.idx), .rdata_o(rdata), .bank_o(reg_bank_o)
    );

    scp_fs_gate #(.FS_WAIT(FS_WAIT)) u_fs (
        .clk(clk), .rst_n(rst_n), .pdown_i(pdown_o),
        .fs_rise_i(fs_rise), .pcm_oe_o(pcm_oe)
    );

    // next-state logic
    always_comb begin
        state_nx = state;
        if (abort) begin
            state_nx = ST_CMD;                       // ABORT->CMD
        end else if (byte_done) begin
            unique case (state)
                ST_CMD: begin
                    if (!byte_in[1])     state_nx = ST_CMD;   // CMD->CMD
                    else if (byte_in[2]) state_nx = ST_RDATA; // CMD->RDATA
                    else                 state_nx = ST_WDATA; // CMD->WDATA
                end
                ST_WDATA: state_nx = ST_CMD;
                ST_RDATA: state_nx = ST_CMD;
                default:  state_nx = ST_CMD;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_CMD;
        else        state <= state_nx;
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt  <= '0;
            shin    <= '0;
            shout   <= '0;
            sdo     <= 1'b0;
            pdown_o <= 1'b1;
            wr_slot <= '0;
        end else begin
            if (abort) begin
                bitcnt <= '0;
            end else if (shift_en) begin
                bitcnt <= bitcnt + 1'b1;
                shin   <= byte_in;
            end
            if (byte_done && state == ST_CMD) begin
                pdown_o <= byte_in[DW-1];
                wr_slot <= cur_slot;
                shout   <= cur_slot.valid ? rdata : '0;
            end
            if (state == ST_RDATA && sclk_rise && !csn_q) begin
                sdo   <= shout[DW-1];
                shout <= {shout[DW-2:0], 1'b0};
            end
        end
    end

    assign sdo_en = (state == ST_RDATA) && !csn_q;
endmodule

// File: rtl/scp_ctrl_port_chk.sv
module scp_ctrl_port_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        csn,
    input logic        fs,
    input logic        sdo_en,
    input logic        pdown_o,
    input logic        pcm_oe,
    input logic [79:0] reg_bank_o
);
    logic [2:0] age;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          age <= '0;
        else if (age != 3'd7) age <= age + 1'b1;
    end

    AST_SDO_OFF_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 3'd2 && csn && $past(csn)) |-> !sdo_en); // R5

    AST_PCM_OFF_PDOWN: assert property (@(posedge clk) disable iff (!rst_n)
        pdown_o |-> !pcm_oe); // R10

    AST_PCM_AFTER_FS: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 3'd3 && $rose(pcm_oe)) |-> $past(fs, 2)); // R10

    AST_BANK_HOLD_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 3'd4 && csn && $past(csn) && $past(csn, 2) && $past(csn, 3))
        |-> $stable(reg_bank_o)); // R2

    AST_PWR_HOLD_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 3'd4 && csn && $past(csn) && $past(csn, 2) && $past(csn, 3))
        |-> $stable(pdown_o)); // R6
endmodule

bind scp_ctrl_port scp_ctrl_port_chk u_chk (
    .clk(clk), .rst_n(rst_n), .csn(csn), .fs(fs), .sdo_en(sdo_en),
    .pdown_o(pdown_o), .pcm_oe(pcm_oe), .reg_bank_o(reg_bank_o)
);

// File: tb/scp_ctrl_port_tb_top.sv
`timescale 1ns/1ps
module scp_ctrl_port_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic csn = 1'b1, sclk = 1'b0, sdi = 1'b0, fs = 1'b0;
    logic sdo, sdo_en, pdown_o, pcm_oe;
    logic [79:0] reg_bank_o;

    always #2.5 clk = ~clk;

    scp_ctrl_port dut_i (
        .clk(clk), .rst_n(rst_n), .csn(csn), .sclk(sclk), .sdi(sdi), .fs(fs),
        .sdo(sdo), .sdo_en(sdo_en), .pdown_o(pdown_o), .pcm_oe(pcm_oe),
        .reg_bank_o(reg_bank_o)
    );

    int n_chk = 0, n_fail = 0;
    logic [79:0] exp_bank = '0;
    logic        rd_en_ok;

    task automatic chk(input string req, input logic [79:0] act, input logic [79:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sel;   csn = 1'b0; wclk(2); endtask
    task automatic desel; wclk(2); csn = 1'b1; wclk(6); endtask

    // one byte, MSB first; returns bits seen on sdo and whether sdo_en stayed high
    task automatic xfer(input logic [7:0] din, output logic [7:0] dout);
        rd_en_ok = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            sdi = din[i];
            sclk = 1'b1; wclk(4);
            dout[i] = sdo;
            if (sdo_en !== 1'b1) rd_en_ok = 1'b0;
            sclk = 1'b0; wclk(4);
        end
    endtask

    task automatic pulse_fs;
        fs = 1'b1; wclk(3); fs = 1'b0; wclk(3);
    endtask

    // {split, slot[3:0], byte1, byte2}
    localparam logic [20:0] VEC [8] = '{
        {1'b0, 4'd0, 8'h82, 8'hA5},
        {1'b1, 4'd2, 8'h92, 8'h3C},
        {1'b0, 4'd1, 8'h8A, 8'h0F},
        {1'b1, 4'd9, 8'hD2, 8'h81},
        {1'b0, 4'd8, 8'hCA, 8'h7E},
        {1'b1, 4'd4, 8'hAA, 8'hC3},
        {1'b0, 4'd7, 8'hC2, 8'hFF},
        {1'b1, 4'd5, 8'hB2, 8'h01}
    };

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] d;
        wclk(3);
        // R1 reset state
        chk("R1 pdown", {79'd0, pdown_o}, 80'd1);
        chk("R1 bank", reg_bank_o, 80'd0);
        chk("R1 enables", {78'd0, sdo_en, pcm_oe}, 80'd0);
        rst_n = 1'b1;
        wclk(3);

        foreach (VEC[k]) begin
            logic       sp = VEC[k][20];
            logic [3:0] sl = VEC[k][19:16];
            logic [7:0] b1 = VEC[k][15:8];
            logic [7:0] b2 = VEC[k][7:0];
            sel; xfer(b1, d);
            if (sp) begin desel; sel; end
            xfer(b2, d); desel;
            exp_bank[sl*8 +: 8] = b2;
            chk(sp ? "R3 split write" : "R2 write", reg_bank_o, exp_bank);
            sel; xfer(b1 | 8'h04, d);
            if (sp) begin
                desel;
                chk("R5 sdo_en off between windows", {79'd0, sdo_en}, 80'd0);
                sel;
            end
            xfer(8'h00, d);
            chk("R4 read data", {72'd0, d}, {72'd0, b2});
            chk("R4 sdo_en in read", {79'd0, rd_en_ok}, 80'd1);
            desel;
            chk("R5 sdo_en off cs high", {79'd0, sdo_en}, 80'd0);
        end
        chk("R6 still down", {79'd0, pdown_o}, 80'd1);

        // R7/R11: single-byte power-up, then write and read, csn held low
        sel;
        xfer(8'h00, d);
        chk("R7 single-byte power up", {79'd0, pdown_o}, 80'd0);
        xfer(8'h22, d); xfer(8'h5A, d);
        exp_bank[3*8 +: 8] = 8'h5A;
        chk("R11 back-to-back write", reg_bank_o, exp_bank);
        xfer(8'h26, d); xfer(8'h00, d);
        chk("R11 back-to-back read", {72'd0, d}, {72'd0, 8'h5A});
        desel;

        // R10 frame sync gating
        chk("R10 no fs yet", {79'd0, pcm_oe}, 80'd0);
        pulse_fs;
        chk("R10 after first fs", {79'd0, pcm_oe}, 80'd0);
        pulse_fs;
        chk("R10 after second fs", {79'd0, pcm_oe}, 80'd1);

        // R6: write carrying P=1 powers down and still writes
        sel; xfer(8'h82, d); xfer(8'h44, d); desel;
        exp_bank[7:0] = 8'h44;
        chk("R6 write with P=1", reg_bank_o, exp_bank);
        chk("R6 powered down", {78'd0, pdown_o, pcm_oe}, 80'd2);

        // R10 count restarts after next power-up
        sel; xfer(8'h00, d); desel;
        pulse_fs;
        chk("R10 restart one fs", {79'd0, pcm_oe}, 80'd0);
        pulse_fs;
        chk("R10 restart two fs", {79'd0, pcm_oe}, 80'd1);

        // R8: partial byte discarded
        sel;
        for (int i = 0; i < 3; i++) begin
            sdi = 1'b1; sclk = 1'b1; wclk(4); sclk = 1'b0; wclk(4);
        end
        desel;
        sel; xfer(8'h02, d); xfer(8'h11, d); desel;
        exp_bank[7:0] = 8'h11;
        chk("R8 abort then write", reg_bank_o, exp_bank);

        // R9: unmapped address
        sel; xfer(8'h9A, d); xfer(8'hEE, d); desel;
        chk("R9 unmapped write ignored", reg_bank_o, exp_bank);
        chk("R9 P bit applied", {79'd0, pdown_o}, 80'd1);
        sel; xfer(8'h1E, d); xfer(8'h00, d); desel;
        chk("R9 unmapped read zero", {72'd0, d}, 80'd0);
        chk("R9 P bit on read", {79'd0, pdown_o}, 80'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule